// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a virtual address into a physical address by reading one page table entry from memory for every request. A requester presents a virtual address, an access type (read or write) and a privilege mode (user or supervisor) on a valid/ready handshake. The block adds the virtual page number, scaled to a two-byte entry, to a base register and issues one read on a simple memory request/response port. When the entry comes back, the block checks its present flag and its permission flags. It then returns either the physical address or a fault code on a response valid/ready handshake.

The block has no translation cache. Each request starts a fresh fetch, and only one translation is in flight at a time. The base register is loaded through a separate write port and resets to zero. With the default parameters the addresses are 16 bits wide, pages are 256 bytes, and entries are 16 bits.

The entry fields are as follows. Bit 15 marks the entry as present. Bit 14 restricts the page to supervisor mode. Bit 13 allows reads and bit 12 allows writes. Bits 7..0 hold the physical page number, and bits 11..8 are ignored.

Top module: `pt_walker`

## Requirements
- R1: After a synchronous reset, `req_ready` is 1, `mem_req_valid` and `rsp_valid` are 0, and the base register is 0.
- R2: The entry read address is the base register plus twice the virtual page number (`vaddr[15:8]`), taken modulo 2^16.
- R3: Each translation issues exactly one memory read. `mem_req_valid` and `mem_req_addr` stay unchanged while `mem_req_ready` is low, and `mem_req_valid` drops in the cycle after the request handshake.
- R4: `req_ready` is 1 only when the block is idle. It goes low on acceptance and stays low until the response handshake completes.
- R5: An entry with bit 15 clear gives `rsp_fault` = 01 (not present) and `rsp_paddr` = 0, whatever its permission bits are.
- R6: A user-mode access (`req_user` = 1) to a present entry with bit 14 set gives `rsp_fault` = 10 (protection) and `rsp_paddr` = 0. Supervisor mode ignores bit 14.
- R7: For a present entry, a read with bit 13 clear or a write with bit 12 clear gives `rsp_fault` = 10 and `rsp_paddr` = 0. This includes writes to pages that are readable but not writable.
- R8: A present, permitted access gives `rsp_fault` = 00 and `rsp_paddr` = {entry[7:0], vaddr[7:0]}. Entry bits 11..8 do not affect the result.
- R9: `rsp_valid`, `rsp_paddr` and `rsp_fault` hold steady until `rsp_ready` is seen high.
- R10: A base register write while a translation is in progress is ignored. A write while idle takes effect for the following translations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| base_we | input | 1 | Base register write strobe |
| base_wdata | input | 16 | Base register write value |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 16 | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_user | input | 1 | 1 = user mode, 0 = supervisor mode |
| mem_req_valid | output | 1 | Entry read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 16 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data valid |
| mem_rsp_data | input | 16 | Entry read from memory |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_paddr | output | 16 | Physical address, 0 on fault |
| rsp_fault | output | 2 | 00 ok, 01 not present, 10 protection |

## Verification
The bench sweeps all 256 page numbers under every pairing of read/write and user/supervisor. Each page's entry flags and frame number come from arithmetic on the page number, so every mix of present, supervisor, readable and writable occurs. This separates the precedence of the not-present fault from the three protection causes, including the readable-but-not-writable write case. The sweep is repeated with a zero base, a mid-range base and a base near the top of the address space, which tells correct scaling of the page number apart from wrap-around errors. Stalls on the memory request and on the result, together with base writes made in mid-walk, show that the handshakes hold their values and that the base register is protected while a walk runs.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int VA_W  = 16,
  parameter int PA_W  = 16,
  parameter int OFS_W = 8,
  parameter int ENT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             base_we,
  input  logic [PA_W-1:0]  base_wdata,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_write,
  input  logic             req_user,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [ENT_W-1:0] mem_rsp_data,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic [1:0]       rsp_fault
);
  localparam int VPN_W = VA_W - OFS_W;
  localparam int PPN_W = PA_W - OFS_W;
  localparam int V_BIT = ENT_W - 1;
  localparam int S_BIT = ENT_W - 2;
  localparam int R_BIT = ENT_W - 3;
  localparam int W_BIT = ENT_W - 4;
  localparam logic [1:0] F_OK = 2'b00, F_NP = 2'b01, F_PROT = 2'b10;

  typedef enum logic [1:0] {IDLE, FETCH, WAIT, DONE} walk_t;
  walk_t state;

  logic [PA_W-1:0] base_q;
  logic [VA_W-1:0] va_q;
  logic            wr_q, usr_q;
  logic [PA_W-1:0] paddr_q;
  logic [1:0]      fault_q;

  logic [VPN_W-1:0] vpn;
  logic [1:0]       chk;
  logic             unused_bits;

  assign vpn           = va_q[VA_W-1:OFS_W];
  assign req_ready     = (state == IDLE);
  assign mem_req_valid = (state == FETCH);
  assign mem_req_addr  = base_q + (PA_W'(vpn) << 1);
  assign rsp_valid     = (state == DONE);
  assign rsp_paddr     = paddr_q;
  assign rsp_fault     = fault_q;
  assign unused_bits   = ^mem_rsp_data[W_BIT-1:PPN_W];

  always_comb begin
    if (!mem_rsp_data[V_BIT])
      chk = F_NP;
    else if ((usr_q && mem_rsp_data[S_BIT]) ||
             (!wr_q && !mem_rsp_data[R_BIT]) ||
             (wr_q && !mem_rsp_data[W_BIT]))
      chk = F_PROT;
    else
      chk = F_OK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= IDLE;
      base_q  <= '0;
      va_q    <= '0;
      wr_q    <= 1'b0;
      usr_q   <= 1'b0;
      paddr_q <= '0;
      fault_q <= F_OK;
    end else begin
      if (base_we && state == IDLE)
        base_q <= base_wdata;
      case (state)
        IDLE: if (req_valid) begin
          va_q  <= req_vaddr;
          wr_q  <= req_write;
          usr_q <= req_user;
          state <= FETCH;
        end
        FETCH: if (mem_req_ready) state <= WAIT;
        WAIT: if (mem_rsp_valid) begin
          fault_q <= chk;
          paddr_q <= (chk == F_OK) ? {mem_rsp_data[PPN_W-1:0], va_q[OFS_W-1:0]} : '0;
          state   <= DONE;
        end
        DONE: if (rsp_ready) state <= IDLE;
        default: state <= IDLE;
      endcase
    end
  end

  // R3
  mreq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
  // R3
  mreq_single_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && mem_req_ready |=> !mem_req_valid);
  // R4
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> !req_ready);
  // R4
  idle_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(req_ready && (rsp_valid || mem_req_valid)));
  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault));
  // R5
  fault_zero_pa_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_fault != F_OK |-> rsp_paddr == '0);
  // R8
  fault_code_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> rsp_fault != 2'b11);
endmodule

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        base_we;
  logic [15:0] base_wdata;
  logic        req_valid;
  logic        req_ready;
  logic [15:0] req_vaddr;
  logic        req_write;
  logic        req_user;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [15:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [15:0] mem_rsp_data;
  logic        rsp_valid;
  logic        rsp_ready;
  logic [15:0] rsp_paddr;
  logic [1:0]  rsp_fault;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_walker u_pt_walker (
    .clk(clk), .rst(rst), .base_we(base_we), .base_wdata(base_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_user(req_user),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] entry_of(input logic [7:0] vpn);
    logic [15:0] e;
    e[15]    = (vpn[2:0] != 3'd0);
    e[14]    = vpn[3];
    e[13]    = vpn[4];
    e[12]    = vpn[5];
    e[11:8]  = {vpn[7:6], vpn[1:0]};
    e[7:0]   = vpn ^ 8'hA5;
    return e;
  endfunction

  task automatic walk(input logic [15:0] base, input logic [7:0] vpn, input logic [1:0] acc);
    logic [15:0] ent, exp_addr, exp_pa, va;
    logic [1:0]  exp_f;
    logic        wr, usr, stall_m, stall_r, poke;
    wr  = acc[0];
    usr = acc[1];
    va  = {vpn, 8'(vpn * 3 + acc)};
    ent = entry_of(vpn);
    exp_addr = base + {7'd0, vpn, 1'b0};
    if (!ent[15]) exp_f = 2'b01;
    else if ((usr && ent[14]) || (!wr && !ent[13]) || (wr && !ent[12])) exp_f = 2'b10;
    else exp_f = 2'b00;
    exp_pa  = (exp_f == 2'b00) ? {ent[7:0], va[7:0]} : 16'h0;
    stall_m = (vpn % 3 == 0);
    stall_r = (vpn % 5 == 0);
    poke    = (vpn % 7 == 1);

    @(negedge clk);
    check("R4 ready when idle", {31'd0, req_ready}, 1);
    req_valid = 1'b1; req_vaddr = va; req_write = wr; req_user = usr;
    @(negedge clk);
    req_valid = 1'b0;
    check("R2 entry address", {16'd0, mem_req_addr}, {16'd0, exp_addr});
    check("R3 read issued", {31'd0, mem_req_valid}, 1);
    check("R4 busy after accept", {31'd0, req_ready}, 0);
    if (poke) begin
      base_we = 1'b1; base_wdata = ~base;
    end
    if (stall_m) begin
      @(negedge clk);
      base_we = 1'b0;
      check("R3 held while stalled", {15'd0, mem_req_valid, mem_req_addr}, {15'd0, 1'b1, exp_addr});
      check("R10 base write ignored", {16'd0, mem_req_addr}, {16'd0, exp_addr});
    end
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0; base_we = 1'b0;
    check("R3 single read", {31'd0, mem_req_valid}, 0);
    mem_rsp_valid = 1'b1; mem_rsp_data = ent;
    @(negedge clk);
    mem_rsp_valid = 1'b0; mem_rsp_data = 16'hxxxx;
    check("R5 R6 R7 fault code", {30'd0, rsp_fault}, {30'd0, exp_f});
    check("R8 physical address", {16'd0, rsp_paddr}, {16'd0, exp_pa});
    check("R9 result valid", {31'd0, rsp_valid}, 1);
    check("R4 busy until response", {31'd0, req_ready}, 0);
    if (stall_r) begin
      @(negedge clk);
      check("R9 result held", {13'd0, rsp_valid, rsp_fault, rsp_paddr}, {13'd0, 1'b1, exp_f, exp_pa});
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check("R9 result taken", {31'd0, rsp_valid}, 0);
    check("R4 idle again", {31'd0, req_ready}, 1);
  endtask

  task automatic sweep(input logic [15:0] base);
    for (int v = 0; v < 256; v++)
      for (int a = 0; a < 4; a++)
        walk(base, 8'(v), 2'(a));
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    rst = 1'b1; base_we = 1'b0; base_wdata = '0; req_valid = 1'b0; req_vaddr = '0;
    req_write = 1'b0; req_user = 1'b0; mem_req_ready = 1'b0; mem_rsp_valid = 1'b0;
    mem_rsp_data = '0; rsp_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state; zero base checked by the first sweep's addresses
    check("R1 req_ready", {31'd0, req_ready}, 1);
    check("R1 mem_req_valid", {31'd0, mem_req_valid}, 0);
    check("R1 rsp_valid", {31'd0, rsp_valid}, 0);
    sweep(16'h0000);
    foreach (bases[i]) begin
      @(negedge clk);
      base_we = 1'b1; base_wdata = bases[i];
      @(negedge clk);
      base_we = 1'b0;
      // R10 idle write takes effect
      sweep(bases[i]);
    end
    done = 1'b1;
    summary();
    $finish;
  end

  logic [15:0] bases [2] = '{16'h1230, 16'hFF40};
endmodule